// File: doc/BRIEF.md
# Host-Slave Mailbox Port Controller

This block is a byte mailbox between an external master processor and a local slave CPU. The master sees a small strobed bus with chip-select, read and write strobes and an address line that picks the data or the status/command location. The slave sees a register bus with a three-bit address. The block holds a command buffer and an input buffer that the master fills, an output buffer that the slave fills, and a status byte. Three handshake flags sit in the low bits of the status byte, and three sticky interrupt-pending bits are driven toward the slave's interrupt controller through a mask.

The master strobes are registered and pass through a small access state machine with three states. M_IDLE waits for a registered strobe. On a write it emits one write event and moves to M_HOLD_WR. On a read it emits one read event and moves to M_HOLD_RD. Each hold state returns to M_IDLE once its strobe has gone low. An access therefore takes effect on the second clock edge after the strobe is first seen, and it takes effect only once. A master write with the address line high is a write to the status location. It is steered into the command buffer. A write with the line low fills the input buffer. For a master read, one of two select inputs decides whether the status byte or the output buffer is returned, and control bit 2 decides which of the two inputs is used.

The block has two modes. In standard mode, status bit 7 is a general-purpose flag and the command interrupt is the live one. In shared-memory mode, bit 7 is read-only and reports the direction of the last master access, and the input and output interrupts are the live ones.

Top module: `mbox_port`

## Requirements
- R1: Status bit 2 (command empty) is set by a slave read of address 1. A master write with `m_addr`=1 clears it, and the same write sets pending bit 0 (command full) and loads the command buffer.
- R2: Status bit 1 (input empty) is set by a slave read of address 2. A master write with `m_addr`=0 clears it, and the same write sets pending bit 1 (input full) and loads the input buffer.
- R3: Status bit 0 (output full) is set by a slave write of address 3, which also loads the output buffer. A master read that returns the output buffer clears it and sets pending bit 2 (output empty).
- R4: A master write to the status location (`m_addr`=1) leaves status bits 7..3 unchanged, and its data appears at slave address 1.
- R5: A slave write to address 0 updates only status bits 7..3. Bits 2..0 keep their values.
- R6: Control bit 0 selects shared-memory mode. In that mode status bit 7 ignores slave writes and reads 1 after a master read and 0 after a master write. In standard mode it is the slave-written bit.
- R7: `irq[k]` = pending[k] AND mask[k] AND mode enable. The mask is at slave address 5, bit k. The enable is standard mode for bit 0, and shared mode for bits 1 and 2.
- R8: After reset the status byte, control, mask and pending registers read 0x00, and `irq` is 0.
- R9: A master read returns the status byte when `m_sel[ctrl bit 2]` is 1, and the output buffer otherwise. A status read leaves the output-full flag and pending bit 2 unchanged.
- R10: Pending bits (slave address 6) are sticky. Writing 1 to bit k clears bit k, and writing 0 leaves it.
- R11: A master strobe held for many cycles causes exactly one flag and pending update.
- R12: When a master event and a slave access to the same flag fall on the same clock edge, the master event wins: the flag is cleared and its pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cs | input | 1 | Master chip-select |
| m_rd | input | 1 | Master read strobe |
| m_wr | input | 1 | Master write strobe |
| m_addr | input | 1 | Master location: 1 status/command, 0 data |
| m_sel | input | 2 | Status-read select lines, one chosen by control bit 2 |
| m_wdata | input | 8 | Master write data |
| m_rdata | output | 8 | Master read data (status byte or output buffer) |
| s_addr | input | 3 | Slave register address |
| s_wr | input | 1 | Slave write strobe, one access per cycle |
| s_rd | input | 1 | Slave read strobe, one access per cycle |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave read data |
| irq | output | 3 | Masked interrupts: bit 0 command full, bit 1 input full, bit 2 output empty |

## Verification
The command and input buffers are each swept over all 256 byte values, with the strobe hold length varied from one to four cycles. This separates correct data capture from stuck or swapped bits, and it shows that the flags update once whatever the strobe length. The output buffer is swept the same way. Reads are also made under every combination of chooser bit and select lines, which shows whether a read returned status or data and whether it wrongly touched the output flag. All 256 slave status writes are repeated in both modes, which exposes writes that leak into the flag bits or into the read-only bit 7. Directed sequences cover same-edge collisions, a clear issued during a held strobe, and the eight mask values against both modes.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;

    // Master access state machine
    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_HOLD_RD = 2'd1,
        M_HOLD_WR = 2'd2
    } mst_state_e;

    // One-cycle events produced by the master access state machine
    typedef struct packed {
        logic wr_cmd;   // write steered to the command buffer
        logic wr_in;    // write to the input buffer
        logic rd_out;   // read that returned the output buffer
        logic rd_any;   // any read
        logic wr_any;   // any write
    } mst_evt_t;

    // Slave register map
    localparam int RA_STATUS = 0;
    localparam int RA_CMD    = 1;
    localparam int RA_IN     = 2;
    localparam int RA_OUT    = 3;
    localparam int RA_CTRL   = 4;
    localparam int RA_MASK   = 5;
    localparam int RA_PEND   = 6;

    // Interrupt channel indices
    localparam int IRQ_N   = 3;
    localparam int IRQ_CBF = 0;
    localparam int IRQ_IBF = 1;
    localparam int IRQ_OBE = 2;

    // Handshake flag count and first user status bit
    localparam int FLAG_N  = 3;
    localparam int USER_LO = 3;

endpackage

// File: rtl/mbox_mst_fsm.sv
`timescale 1ns/1ps
module mbox_mst_fsm
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_cs,
    input  logic              m_rd,
    input  logic              m_wr,
    input  logic              m_addr,
    input  logic              stat_sel,
    input  logic [DATA_W-1:0] m_wdata,
    output mst_evt_t          evt,
    output logic [DATA_W-1:0] wdata_q,
    output logic              fsm_idle
);

    logic       q_cs, q_rd, q_wr, q_addr, q_stat;
    mst_state_e st_q, st_d;

    // Input capture stage for the master strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cs    <= 1'b0;
            q_rd    <= 1'b0;
            q_wr    <= 1'b0;
            q_addr  <= 1'b0;
            q_stat  <= 1'b0;
            wdata_q <= '0;
        end else begin
            q_cs    <= m_cs;
            q_rd    <= m_rd;
            q_wr    <= m_wr;
            q_addr  <= m_addr;
            q_stat  <= stat_sel;
            wdata_q <= m_wdata;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= M_IDLE;
        else        st_q <= st_d;
    end

    // Next state and event outputs
    always_comb begin
        st_d = st_q;
        evt  = '0;
        unique case (st_q)
            M_IDLE: begin
                if (q_cs && q_wr) begin
                    st_d       = M_HOLD_WR;
                    evt.wr_any = 1'b1;
                    evt.wr_cmd = q_addr;
                    evt.wr_in  = !q_addr;
                end else if (q_cs && q_rd) begin
                    st_d       = M_HOLD_RD;
                    evt.rd_any = 1'b1;
                    evt.rd_out = !q_stat;
                end
            end
            M_HOLD_RD: begin
                if (!(q_cs && q_rd)) st_d = M_IDLE;
            end
            M_HOLD_WR: begin
                if (!(q_cs && q_wr)) st_d = M_IDLE;
            end
            default: st_d = M_IDLE;
        endcase
    end

    assign fsm_idle = (st_q == M_IDLE);

endmodule

// File: rtl/mbox_regs.sv
`timescale 1ns/1ps
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mst_evt_t          evt,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_wr,
    input  logic              s_rd,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] cmd_buf,
    output logic [DATA_W-1:0] in_buf,
    output logic [DATA_W-1:0] out_buf,
    output logic              shared,
    output logic              stat_chooser
);

    localparam int USER_W = DATA_W - USER_LO;

    logic [FLAG_N-1:0] m_clr, s_set, flag_q;
    logic [USER_W-1:0] user_q;
    logic              last_rd_q;
    logic              wr_stat, wr_out, wr_ctrl;

    assign wr_stat = s_wr && (s_addr == ADDR_W'(RA_STATUS));
    assign wr_out  = s_wr && (s_addr == ADDR_W'(RA_OUT));
    assign wr_ctrl = s_wr && (s_addr == ADDR_W'(RA_CTRL));

    // Flag index equals status bit: 2 command empty, 1 input empty, 0 output full
    assign m_clr = {evt.wr_cmd, evt.wr_in, evt.rd_out};
    assign s_set = {s_rd && (s_addr == ADDR_W'(RA_CMD)),
                    s_rd && (s_addr == ADDR_W'(RA_IN)),
                    wr_out};

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          f_q <= 1'b0;
            else if (m_clr[g])   f_q <= 1'b0;   // master side wins
            else if (s_set[g])   f_q <= 1'b1;
        end
        assign flag_q[g] = f_q;
    end

    // Buffers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_buf <= '0;
            in_buf  <= '0;
            out_buf <= '0;
        end else begin
            if (evt.wr_cmd) cmd_buf <= wdata_q;
            if (evt.wr_in)  in_buf  <= wdata_q;
            if (wr_out)     out_buf <= s_wdata;
        end
    end

    // User status bits; the top one is frozen against slave writes in shared mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            user_q <= '0;
        end else if (wr_stat) begin
            user_q[USER_W-2:0] <= s_wdata[DATA_W-2:USER_LO];
            if (!shared) user_q[USER_W-1] <= s_wdata[DATA_W-1];
        end
    end

    // Direction of the newest master access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          last_rd_q <= 1'b0;
        else if (evt.rd_any) last_rd_q <= 1'b1;
        else if (evt.wr_any) last_rd_q <= 1'b0;
    end

    // Control: bit 0 mode, bit 2 select-line chooser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shared       <= 1'b0;
            stat_chooser <= 1'b0;
        end else if (wr_ctrl) begin
            shared       <= s_wdata[0];
            stat_chooser <= s_wdata[2];
        end
    end

    always_comb begin
        status                  = '0;
        status[FLAG_N-1:0]      = flag_q;
        status[DATA_W-2:USER_LO] = user_q[USER_W-2:0];
        status[DATA_W-1]        = shared ? last_rd_q : user_q[USER_W-1];
    end

endmodule

// File: rtl/mbox_irq.sv
`timescale 1ns/1ps
module mbox_irq
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] pend_set,
    input  logic [IRQ_N-1:0] pend_clr,
    input  logic             mask_we,
    input  logic [IRQ_N-1:0] mask_wdata,
    input  logic             shared,
    output logic [IRQ_N-1:0] mask,
    output logic [IRQ_N-1:0] pend,
    output logic [IRQ_N-1:0] irq
);

    logic [IRQ_N-1:0] mode_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    for (genvar k = 0; k < IRQ_N; k++) begin : g_pend
        logic p_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          p_q <= 1'b0;
            else if (pend_set[k]) p_q <= 1'b1;   // set wins over clear
            else if (pend_clr[k]) p_q <= 1'b0;
        end
        assign pend[k] = p_q;
        if (k == IRQ_CBF) begin : g_std
            assign mode_en[k] = !shared;
        end else begin : g_shm
            assign mode_en[k] = shared;
        end
    end

    assign irq = pend & mask & mode_en;

endmodule

// File: rtl/mbox_port.sv
`timescale 1ns/1ps
module mbox_port
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_cs,
    input  logic              m_rd,
    input  logic              m_wr,
    input  logic              m_addr,
    input  logic [1:0]        m_sel,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_wr,
    input  logic              s_rd,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] s_rdata,
    output logic [IRQ_N-1:0]  irq
);

    mst_evt_t          evt;
    logic [DATA_W-1:0] wdata_q, status, cmd_buf, in_buf, out_buf;
    logic              shared, stat_chooser, stat_sel, fsm_idle;
    logic [IRQ_N-1:0]  mask, pend, pend_set, pend_clr;
    logic              ev_cmd, ev_in, ev_out, ev_wr, ev_any, s_wr_status;

    assign stat_sel = m_sel[stat_chooser];

    mbox_mst_fsm #(.DATA_W(DATA_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .m_cs(m_cs), .m_rd(m_rd), .m_wr(m_wr),
        .m_addr(m_addr), .stat_sel(stat_sel), .m_wdata(m_wdata),
        .evt(evt), .wdata_q(wdata_q), .fsm_idle(fsm_idle)
    );

    mbox_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wdata_q(wdata_q),
        .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd), .s_wdata(s_wdata),
        .status(status), .cmd_buf(cmd_buf), .in_buf(in_buf), .out_buf(out_buf),
        .shared(shared), .stat_chooser(stat_chooser)
    );

    always_comb begin
        pend_set          = '0;
        pend_set[IRQ_CBF] = evt.wr_cmd;
        pend_set[IRQ_IBF] = evt.wr_in;
        pend_set[IRQ_OBE] = evt.rd_out;
    end

    assign pend_clr = (s_wr && (s_addr == ADDR_W'(RA_PEND))) ? s_wdata[IRQ_N-1:0] : '0;

    mbox_irq i_irq (
        .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .pend_clr(pend_clr),
        .mask_we(s_wr && (s_addr == ADDR_W'(RA_MASK))), .mask_wdata(s_wdata[IRQ_N-1:0]),
        .shared(shared), .mask(mask), .pend(pend), .irq(irq)
    );

    // Master read data
    assign m_rdata = stat_sel ? status : out_buf;

    // Slave read data
    always_comb begin
        s_rdata = '0;
        unique case (s_addr)
            ADDR_W'(RA_STATUS): s_rdata = status;
            ADDR_W'(RA_CMD):    s_rdata = cmd_buf;
            ADDR_W'(RA_IN):     s_rdata = in_buf;
            ADDR_W'(RA_OUT):    s_rdata = out_buf;
            ADDR_W'(RA_CTRL): begin
                s_rdata[0] = shared;
                s_rdata[2] = stat_chooser;
            end
            ADDR_W'(RA_MASK):   s_rdata[IRQ_N-1:0] = mask;
            ADDR_W'(RA_PEND):   s_rdata[IRQ_N-1:0] = pend;
            default:            s_rdata = '0;
        endcase
    end

    // Named event views for the checker
    assign ev_cmd      = evt.wr_cmd;
    assign ev_in       = evt.wr_in;
    assign ev_out      = evt.rd_out;
    assign ev_wr       = evt.wr_any;
    assign ev_any      = evt.wr_any | evt.rd_any;
    assign s_wr_status = s_wr && (s_addr == ADDR_W'(RA_STATUS));

endmodule

// File: rtl/mbox_port_chk.sv
`timescale 1ns/1ps
module mbox_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_cmd,
    input logic              ev_in,
    input logic              ev_out,
    input logic              ev_wr,
    input logic              ev_any,
    input logic              fsm_idle,
    input logic              shared,
    input logic              s_wr_status,
    input logic [DATA_W-1:0] status,
    input logic [2:0]        pend,
    input logic [2:0]        pend_clr,
    input logic [2:0]        mask,
    input logic [2:0]        irq
);

    AST_CMD_EVENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cmd |=> (!status[2] && pend[0]));  // R1
    AST_IN_EVENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in |=> (!status[1] && pend[1]));  // R2
    AST_OUT_EVENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_out |=> (!status[0] && pend[2]));  // R3
    AST_STATUS_WRITE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmd && !s_wr_status) |=> (status[DATA_W-2:3] == $past(status[DATA_W-2:3])));  // R4
    AST_SLAVE_FLAG_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr_status && !ev_any) |=> (status[2:0] == $past(status[2:0])));  // R5
    AST_SHARED_WRITE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (shared && ev_wr) |=> (!shared || !status[DATA_W-1]));  // R6
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~mask) == 3'b000));  // R7
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~pend) == 3'b000));  // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(pend & ~pend_clr)) == $past(pend & ~pend_clr)));  // R10
    AST_ONE_EVENT_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !fsm_idle |-> !ev_any);  // R11

endmodule

bind mbox_port mbox_port_chk #(.DATA_W(DATA_W)) i_mbox_port_chk (
    .clk(clk), .rst_n(rst_n), .ev_cmd(ev_cmd), .ev_in(ev_in), .ev_out(ev_out),
    .ev_wr(ev_wr), .ev_any(ev_any), .fsm_idle(fsm_idle), .shared(shared),
    .s_wr_status(s_wr_status), .status(status), .pend(pend), .pend_clr(pend_clr),
    .mask(mask), .irq(irq)
);

// File: tb/test_mbox_port.sv
`timescale 1ns/1ps
module test_mbox_port;

    localparam int WD_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_cs, m_rd, m_wr, m_addr;
    logic [1:0] m_sel;
    logic [7:0] m_wdata, m_rdata;
    logic [2:0] s_addr;
    logic       s_wr, s_rd;
    logic [7:0] s_wdata, s_rdata;
    logic [2:0] irq;

    always #2.5 clk = ~clk;

    mbox_port i_mbox_port (
        .clk(clk), .rst_n(rst_n), .m_cs(m_cs), .m_rd(m_rd), .m_wr(m_wr),
        .m_addr(m_addr), .m_sel(m_sel), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd), .s_wdata(s_wdata),
        .s_rdata(s_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the requirements
    logic [7:0] e_cmd, e_in, e_out;
    logic [7:3] e_user;
    logic       e_cbe, e_ibe, e_obf, e_lastrd, e_sh, e_csel;
    logic [2:0] e_mask, e_pend;

    function automatic logic [7:0] e_status();
        return {e_sh ? e_lastrd : e_user[7], e_user[6:3], e_cbe, e_ibe, e_obf};
    endfunction

    function automatic logic [2:0] e_irq();
        return e_pend & e_mask & {e_sh, e_sh, ~e_sh};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic s_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        s_addr = a; s_wdata = d; s_wr = 1'b1;
        @(negedge clk);
        s_wr = 1'b0;
        unique case (a)
            3'd0: begin e_user[6:3] = d[6:3]; if (!e_sh) e_user[7] = d[7]; end
            3'd3: begin e_out = d; e_obf = 1'b1; end
            3'd4: begin e_sh = d[0]; e_csel = d[2]; end
            3'd5: e_mask = d[2:0];
            3'd6: e_pend = e_pend & ~d[2:0];
            default: ;
        endcase
    endtask

    task automatic s_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        s_addr = a; s_rd = 1'b1;
        #1 d = s_rdata;
        @(negedge clk);
        s_rd = 1'b0;
        if (a == 3'd1) e_cbe = 1'b1;
        if (a == 3'd2) e_ibe = 1'b1;
    endtask

    task automatic m_write(input logic is_cmd, input logic [7:0] d, input int hold);
        @(negedge clk);
        m_cs = 1'b1; m_wr = 1'b1; m_addr = is_cmd; m_wdata = d;
        repeat (hold) @(negedge clk);
        m_cs = 1'b0; m_wr = 1'b0;
        repeat (2) @(negedge clk);
        if (is_cmd) begin e_cmd = d; e_cbe = 1'b0; e_pend[0] = 1'b1; end
        else begin e_in = d; e_ibe = 1'b0; e_pend[1] = 1'b1; end
        e_lastrd = 1'b0;
    endtask

    task automatic m_read(input string req, input int hold);
        logic [7:0] d, exp;
        logic       ssel;
        ssel = m_sel[e_csel];
        exp  = ssel ? e_status() : e_out;
        @(negedge clk);
        m_cs = 1'b1; m_rd = 1'b1;
        #1 d = m_rdata;
        repeat (hold) @(negedge clk);
        m_cs = 1'b0; m_rd = 1'b0;
        repeat (2) @(negedge clk);
        chk(req, d, exp);
        e_lastrd = 1'b1;
        if (!ssel) begin e_obf = 1'b0; e_pend[2] = 1'b1; end
    endtask

    task automatic chk_status(input string req);
        logic [7:0] d;
        s_read(3'd0, d);
        chk(req, d, e_status());
    endtask

    task automatic chk_pend(input string req);
        logic [7:0] d;
        s_read(3'd6, d);
        chk(req, d, {5'b0, e_pend});
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL all: watchdog at %0d cycles, got hang expected completion", WD_CYCLES);
        finish_run();
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0;
        m_cs = 0; m_rd = 0; m_wr = 0; m_addr = 0; m_sel = 2'b00; m_wdata = 0;
        s_addr = 0; s_wr = 0; s_rd = 0; s_wdata = 0;
        e_cmd = 0; e_in = 0; e_out = 0; e_user = 0;
        e_cbe = 0; e_ibe = 0; e_obf = 0; e_lastrd = 0; e_sh = 0; e_csel = 0;
        e_mask = 0; e_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        chk("R8", {5'b0, irq}, 8'h00);
        chk_status("R8");
        chk_pend("R8");
        s_read(3'd4, d); chk("R8", d, 8'h00);
        s_read(3'd5, d); chk("R8", d, 8'h00);

        // R1 / R4: command sweep with user status bits preset
        s_write(3'd0, 8'hA8);
        for (int v = 0; v < 256; v++) begin
            s_read(3'd1, d);
            chk_status("R1");
            m_write(1'b1, 8'(v), (v % 4) + 1);
            chk_status("R4");
            chk_pend("R1");
            s_read(3'd1, d); chk("R4", d, 8'(v));
            s_write(3'd6, 8'h01);
            chk_pend("R10");
        end

        // R2: input buffer sweep
        for (int v = 0; v < 256; v++) begin
            s_read(3'd2, d);
            chk_status("R2");
            m_write(1'b0, 8'(255 - v), (v % 4) + 1);
            chk_status("R2");
            chk_pend("R2");
            s_read(3'd2, d); chk("R2", d, 8'(255 - v));
            s_write(3'd6, 8'h02);
        end

        // R3: output buffer sweep
        for (int v = 0; v < 256; v++) begin
            s_write(3'd3, 8'(v ^ 8'h5A));
            chk_status("R3");
            m_read("R3", (v % 4) + 1);
            chk_status("R3");
            chk_pend("R3");
            s_write(3'd6, 8'h04);
        end

        // R9: select line and chooser combinations
        for (int c = 0; c < 2; c++) begin
            s_write(3'd4, c[0] ? 8'h04 : 8'h00);
            for (int s = 0; s < 4; s++) begin
                m_sel = 2'(s);
                s_write(3'd3, 8'(16 * c + s + 8'h30));
                m_read("R9", 1);
                chk_status("R9");
                chk_pend("R9");
                s_write(3'd6, 8'h04);
            end
        end
        m_sel = 2'b00;
        s_write(3'd4, 8'h00);

        // R5 / R6: slave status writes in both modes
        for (int sh = 0; sh < 2; sh++) begin
            s_write(3'd4, 8'(sh));
            for (int v = 0; v < 256; v++) begin
                s_write(3'd0, 8'(v));
                chk_status(sh ? "R6" : "R5");
            end
        end
        // R6: bit 7 follows master direction in shared mode
        m_read("R6", 1);
        chk_status("R6");
        m_write(1'b0, 8'h11, 1);
        chk_status("R6");
        m_read("R6", 2);
        chk_status("R6");
        s_write(3'd0, 8'h00);
        chk_status("R6");

        // R7: all pending set, every mask in both modes
        s_write(3'd4, 8'h00);
        m_write(1'b1, 8'h01, 1);
        m_write(1'b0, 8'h02, 1);
        s_write(3'd3, 8'h03);
        m_read("R3", 1);
        for (int sh = 0; sh < 2; sh++) begin
            s_write(3'd4, 8'(sh));
            for (int mk = 0; mk < 8; mk++) begin
                s_write(3'd5, 8'(mk));
                @(negedge clk);
                chk("R7", {5'b0, irq}, {5'b0, e_irq()});
            end
        end

        // R10: stickiness and per-bit clear
        s_write(3'd4, 8'h00);
        s_write(3'd5, 8'h07);
        repeat (10) @(negedge clk);
        chk_pend("R10");
        s_write(3'd6, 8'h02);
        chk_pend("R10");
        chk("R10", {5'b0, irq}, {5'b0, e_irq()});
        s_write(3'd6, 8'h05);
        chk_pend("R10");
        chk("R10", {5'b0, irq}, 8'h00);

        // R11: clear during a held write strobe is not undone
        @(negedge clk);
        m_cs = 1'b1; m_wr = 1'b1; m_addr = 1'b1; m_wdata = 8'h9E;
        repeat (3) @(negedge clk);
        e_cmd = 8'h9E; e_cbe = 1'b0; e_pend[0] = 1'b1; e_lastrd = 1'b0;
        s_write(3'd6, 8'h01);
        s_read(3'd1, d);
        repeat (4) @(negedge clk);
        m_cs = 1'b0; m_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk_pend("R11");
        chk_status("R11");
        // R11: output refill during a held read strobe stays full
        s_write(3'd3, 8'h21);
        @(negedge clk);
        m_cs = 1'b1; m_rd = 1'b1;
        repeat (3) @(negedge clk);
        e_obf = 1'b0; e_pend[2] = 1'b1; e_lastrd = 1'b1;
        s_write(3'd3, 8'h22);
        repeat (4) @(negedge clk);
        m_cs = 1'b0; m_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk_status("R11");
        s_write(3'd6, 8'h07);
        chk_pend("R11");

        // R12: same-edge collisions, master wins
        @(negedge clk);
        m_cs = 1'b1; m_wr = 1'b1; m_addr = 1'b1; m_wdata = 8'h5C;
        @(negedge clk);
        s_addr = 3'd1; s_rd = 1'b1;
        @(negedge clk);
        s_rd = 1'b0; m_cs = 1'b0; m_wr = 1'b0;
        repeat (2) @(negedge clk);
        e_cmd = 8'h5C; e_cbe = 1'b0; e_pend[0] = 1'b1; e_lastrd = 1'b0;
        chk_status("R12");
        chk_pend("R12");

        s_write(3'd3, 8'h33);
        @(negedge clk);
        m_cs = 1'b1; m_rd = 1'b1;
        @(negedge clk);
        s_addr = 3'd3; s_wdata = 8'h44; s_wr = 1'b1;
        @(negedge clk);
        s_wr = 1'b0; m_cs = 1'b0; m_rd = 1'b0;
        repeat (2) @(negedge clk);
        e_out = 8'h44; e_obf = 1'b0; e_pend[2] = 1'b1; e_lastrd = 1'b1;
        chk_status("R12");
        chk_pend("R12");
        s_read(3'd3, d); chk("R12", d, 8'h44);

        finish_run();
    end

endmodule